// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Registered Status Byte

This block computes a single arithmetic, logic or shift result in one combinational pass from two operands and a four-bit operation code. It also keeps an eight-bit status byte and a separate signed-overflow bit in registers. Both load on a rising clock edge when the flag-write enable is high. The datapath width is set by the parameter `W`, which defaults to 16 and must be at least 8.

Compare subtracts the operands only to set the flags. It reports its output as not for writeback. Increment and decrement keep the previous carry. A shift by zero also keeps the carry, and any other shift loads carry with the last bit shifted out. Codes 12 to 15 are unassigned and change nothing.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, INC=2, DEC=3, AND=4, OR=5, XOR=6, NOT=7, SHL=8, SHR=9, SAR=10, CMP=11. ADD gives A+B, SUB gives A-B, INC gives A+1 and DEC gives A-1, all modulo 2^W, and each drives `result_valid_o` high.
- R2: AND, OR and XOR combine A and B bitwise. NOT gives the complement of A and ignores B. Each drives `result_valid_o` high.
- R3: The shift amount is the low log2(W) bits of B. SHL fills with zeros from the bottom. SHR fills with zeros from the top. SAR replicates A's top bit.
- R4: CMP drives `result_valid_o` low and `result_o` to zero. Its flags are exactly those SUB would produce for the same operands.
- R5: The status byte has Sign at bit 7, Zero at bit 6, Aux-carry at bit 4, Parity at bit 2 and Carry at bit 0. Bits 5, 3 and 1 always read 0. On a flag write, Zero is set when the value is all zeros and Sign copies its top bit. The value is the result, or the difference for CMP.
- R6: Parity is 1 when the low 8 bits of that value hold an even number of ones.
- R7: Carry is the carry out of ADD, or the borrow (A < B unsigned) of SUB and CMP. Aux-carry is the carry or borrow from bit 3 into bit 4 for all five arithmetic codes.
- R8: `overflow_o` captures signed overflow on ADD, SUB, CMP, INC and DEC. Logic operations and shifts clear it.
- R9: AND, OR, XOR and NOT clear Carry and Aux-carry. Shifts clear Aux-carry.
- R10: A shift with a nonzero amount loads Carry with the last bit moved out. A zero amount leaves Carry unchanged.
- R11: INC and DEC leave Carry at its previous value.
- R12: An active-low asynchronous reset clears the status byte to 0x00 and `overflow_o` to 0. The byte and the overflow bit change only at a rising edge with `flag_we_i` high.
- R13: Codes 12 to 15 drive `result_valid_o` low and `result_o` to zero. They leave the status byte and `overflow_o` unchanged even with `flag_we_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand, or shift amount in its low bits |
| flag_we_i | input | 1 | Loads the status byte and overflow bit at the next edge |
| result_o | output | W | Combinational result |
| result_valid_o | output | 1 | High when the result is meant for writeback |
| flags_o | output | 8 | Registered status byte |
| overflow_o | output | 1 | Registered signed-overflow bit |

## Verification
The hardest situations to reach are those where a flag must keep its old value. Examples are Carry across INC/DEC, Carry across a zero-length shift, and the whole byte across an unassigned code. Each needs a known, nonzero Carry set up beforehand. Directed sequences first set Carry with a borrowing subtract or an overflowing add, then apply the operation that must preserve it. Random traffic also biases operands toward 0, 0x7FFF, 0x8000 and 0xFFFF, so overflow, borrow and nibble carries occur often.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_SAR = 4'd10,
        OP_CMP = 4'd11
    } alu_op_e;

    // bit positions inside the status byte
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_AUX   = 4;
    localparam int FB_PAR   = 2;
    localparam int FB_CARRY = 0;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flags_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   sum,
    output logic           carry,
    output logic           aux,
    output logic           ovf
);
    logic         sub;
    logic         use_one;
    logic [W-1:0] y;
    logic [W-1:0] yi;
    logic [W:0]   wide;
    logic [4:0]   nib;

    always_comb begin
        use_one = (op == OP_INC) || (op == OP_DEC);
        sub     = (op == OP_SUB) || (op == OP_DEC) || (op == OP_CMP);
        y       = use_one ? W'(1) : b;
        yi      = sub ? ~y : y;
        wide    = {1'b0, a} + {1'b0, yi} + (W+1)'(sub);
        nib     = {1'b0, a[3:0]} + {1'b0, yi[3:0]} + 5'(sub);
        sum     = wide[W-1:0];
        // a subtract reports borrow, the inverse of the adder carry
        carry   = wide[W] ^ sub;
        aux     = nib[4] ^ sub;
        ovf     = (a[W-1] == yi[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_flags_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = 4
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   res,
    output logic           shout
);
    logic [W:0] shl_w;
    logic [W:0] shr_w;
    logic [W:0] sar_w;

    always_comb begin
        // one guard bit on the far side catches the last bit moved out
        shl_w = {1'b0, a} << amt;
        shr_w = {a, 1'b0} >> amt;
        sar_w = $signed({a, 1'b0}) >>> amt;
        res   = '0;
        shout = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_SHL:  begin res = shl_w[W-1:0]; shout = shl_w[W]; end
            OP_SHR:  begin res = shr_w[W:1];   shout = shr_w[0]; end
            OP_SAR:  begin res = sar_w[W:1];   shout = sar_w[0]; end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] d_flags,
    input  logic       d_ovf,
    output logic [7:0] q_flags,
    output logic       q_ovf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_flags <= 8'h00;
            q_ovf   <= 1'b0;
        end else if (we) begin
            q_flags <= d_flags;
            q_ovf   <= d_ovf;
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         flag_we_i,
    output logic [W-1:0] result_o,
    output logic         result_valid_o,
    output logic [7:0]   flags_o,
    output logic         overflow_o
);
    localparam int SHW = $clog2(W);

    alu_op_e        op;
    logic [SHW-1:0] amt;
    logic [W-1:0]   as_sum;
    logic           as_carry, as_aux, as_ovf;
    logic [W-1:0]   bo_res;
    logic           bo_shout;
    logic [7:0]     nxt_flags;
    logic           nxt_ovf;
    logic [W-1:0]   val;
    logic           upd_szp;

    assign op  = alu_op_e'(op_i);
    assign amt = b_i[SHW-1:0];

    alu_addsub #(.W(W)) u_addsub (
        .op(op), .a(a_i), .b(b_i),
        .sum(as_sum), .carry(as_carry), .aux(as_aux), .ovf(as_ovf)
    );

    alu_bitops #(.W(W), .SHW(SHW)) u_bitops (
        .op(op), .a(a_i), .b(b_i), .amt(amt),
        .res(bo_res), .shout(bo_shout)
    );

    always_comb begin
        nxt_flags      = flags_o;
        nxt_ovf        = overflow_o;
        result_o       = '0;
        result_valid_o = 1'b0;
        val            = '0;
        upd_szp        = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                result_o            = as_sum;
                result_valid_o      = 1'b1;
                val                 = as_sum;
                upd_szp             = 1'b1;
                nxt_flags[FB_CARRY] = as_carry;
                nxt_flags[FB_AUX]   = as_aux;
                nxt_ovf             = as_ovf;
            end
            OP_INC, OP_DEC: begin
                result_o          = as_sum;
                result_valid_o    = 1'b1;
                val               = as_sum;
                upd_szp           = 1'b1;
                nxt_flags[FB_AUX] = as_aux;
                nxt_ovf           = as_ovf;
            end
            OP_CMP: begin
                val                 = as_sum;
                upd_szp             = 1'b1;
                nxt_flags[FB_CARRY] = as_carry;
                nxt_flags[FB_AUX]   = as_aux;
                nxt_ovf             = as_ovf;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                result_o            = bo_res;
                result_valid_o      = 1'b1;
                val                 = bo_res;
                upd_szp             = 1'b1;
                nxt_flags[FB_CARRY] = 1'b0;
                nxt_flags[FB_AUX]   = 1'b0;
                nxt_ovf             = 1'b0;
            end
            OP_SHL, OP_SHR, OP_SAR: begin
                result_o          = bo_res;
                result_valid_o    = 1'b1;
                val               = bo_res;
                upd_szp           = 1'b1;
                if (amt != '0) nxt_flags[FB_CARRY] = bo_shout;
                nxt_flags[FB_AUX] = 1'b0;
                nxt_ovf           = 1'b0;
            end
            default: ;
        endcase
        if (upd_szp) begin
            nxt_flags[FB_SIGN] = val[W-1];
            nxt_flags[FB_ZERO] = (val == '0);
            nxt_flags[FB_PAR]  = ~^val[7:0];
        end
        nxt_flags[5] = 1'b0;
        nxt_flags[3] = 1'b0;
        nxt_flags[1] = 1'b0;
    end

    alu_status_reg u_status (
        .clk(clk), .rst_n(rst_n), .we(flag_we_i),
        .d_flags(nxt_flags), .d_ovf(nxt_ovf),
        .q_flags(flags_o), .q_ovf(overflow_o)
    );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         flag_we_i,
    input logic [W-1:0] result_o,
    input logic         result_valid_o,
    input logic [7:0]   flags_o,
    input logic         overflow_o
);
    localparam int SHW = $clog2(W);

    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> ($stable(flags_o) && $stable(overflow_o))); // R12

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b0)); // R5

    AST_CMP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd11) |-> (!result_valid_o && (result_o == '0))); // R4

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && result_valid_o) |=> (flags_o[6] == ($past(result_o) == '0))); // R5

    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && result_valid_o) |=> (flags_o[7] == $past(result_o[W-1]))); // R5

    AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (op_i == 4'd2 || op_i == 4'd3)) |=> (flags_o[0] == $past(flags_o[0]))); // R11

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i >= 4'd4 && op_i <= 4'd7) |=> (!flags_o[0] && !flags_o[4] && !overflow_o)); // R9

    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i >= 4'd8 && op_i <= 4'd10 && b_i[SHW-1:0] == '0)
        |=> (flags_o[0] == $past(flags_o[0]))); // R10

    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd12) |=> ($stable(flags_o) && $stable(overflow_o))); // R13
endmodule

bind alu_flags_unit alu_flags_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op = '0;
    logic [W-1:0] a = '0, b = '0;
    logic         we = 1'b0;
    logic [W-1:0] res;
    logic         rv;
    logic [7:0]   fl;
    logic         ov;

    int checks = 0, fails = 0;
    logic [7:0] m_fl = 8'h00;
    logic       m_ov = 1'b0;

    always #10 clk = ~clk;

    alu_flags_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .flag_we_i(we), .result_o(res), .result_valid_o(rv),
        .flags_o(fl), .overflow_o(ov)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input logic [15:0] v);
        return v[15] ? int'(v) - 65536 : int'(v);
    endfunction

    // independent reference built from the requirement text
    task automatic model(input int o, input logic [15:0] x, input logic [15:0] y,
                         output logic [15:0] r, output logic vld,
                         output logic [7:0] nf, output logic nv);
        int ux = int'(x), uy = int'(y), n = int'(y[3:0]);
        int s;
        logic c = m_fl[0], ac = m_fl[4], vv = m_ov, szp = 1'b1;
        logic [15:0] v;
        r = '0; vld = 1'b1; v = '0;
        case (o)
            0: begin v = 16'(ux + uy); c = (ux + uy) > 65535;
                     ac = ((ux % 16) + (uy % 16)) > 15;
                     s = sx(x) + sx(y); vv = (s > 32767) || (s < -32768); end
            1, 11: begin v = 16'(ux - uy); c = ux < uy; ac = (ux % 16) < (uy % 16);
                     s = sx(x) - sx(y); vv = (s > 32767) || (s < -32768); end
            2: begin v = 16'(ux + 1); ac = (ux % 16) == 15; vv = (x == 16'h7FFF); end
            3: begin v = 16'(ux - 1); ac = (ux % 16) == 0;  vv = (x == 16'h8000); end
            4: begin v = x & y; c = 0; ac = 0; vv = 0; end
            5: begin v = x | y; c = 0; ac = 0; vv = 0; end
            6: begin v = x ^ y; c = 0; ac = 0; vv = 0; end
            7: begin v = ~x;    c = 0; ac = 0; vv = 0; end
            8: begin v = 16'(ux << n); if (n != 0) c = x[16-n]; ac = 0; vv = 0; end
            9: begin v = 16'(ux >> n); if (n != 0) c = x[n-1]; ac = 0; vv = 0; end
            10: begin s = sx(x) >>> n; v = 16'(s); if (n != 0) c = x[n-1]; ac = 0; vv = 0; end
            default: begin vld = 1'b0; szp = 1'b0; end
        endcase
        if (o == 11) vld = 1'b0;
        if (vld) r = v;
        nf = m_fl; nv = m_ov;
        if (szp) begin
            nf = {v[15], (v == 16'h0), 1'b0, ac, 1'b0, ~^v[7:0], 1'b0, c};
            nv = vv;
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic run(input int o, input logic [15:0] x, input logic [15:0] y,
                       input logic w, input string tag);
        logic [15:0] er; logic ev; logic [7:0] ef; logic eo;
        op = 4'(o); a = x; b = y; we = w;
        model(o, x, y, er, ev, ef, eo);
        #5;
        chk(tag, "result", 32'(res), 32'(er));
        chk(tag, "valid", 32'(rv), 32'(ev));
        @(negedge clk);
        if (w) begin m_fl = ef; m_ov = eo; end
        chk(tag, "flags", 32'(fl), 32'(m_fl));
        chk(tag, "overflow", 32'(ov), 32'(m_ov));
    endtask

    function automatic logic [15:0] pick();
        case ($urandom % 6)
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic string tag_of(input int o);
        if (o <= 3) return "R1";
        if (o <= 7) return "R2";
        if (o <= 10) return "R3";
        if (o == 11) return "R4";
        return "R13";
    endfunction

    initial begin
        #4000000;
        fails++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R12", "reset flags", 32'(fl), 32'h00);
        chk("R12", "reset overflow", 32'(ov), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run(0, 16'h7FFF, 16'h0001, 1, "R8");   // signed overflow, aux carry
        run(0, 16'hFFFF, 16'h0001, 1, "R7");   // carry out, zero
        run(0, 16'h000F, 16'h0001, 1, "R7");   // nibble carry only
        run(1, 16'h0000, 16'h0001, 1, "R7");   // borrow
        run(2, 16'hFFFF, 16'h0000, 1, "R11");  // carry kept set
        run(3, 16'h8000, 16'h0000, 1, "R11");  // overflow, carry kept
        run(11, 16'h1234, 16'h1234, 1, "R4");  // equal compare
        run(11, 16'h0001, 16'h0002, 1, "R4");  // compare with borrow
        run(4, 16'h00F3, 16'h000F, 1, "R6");   // two ones: parity set
        run(6, 16'h0007, 16'h0000, 1, "R6");   // three ones: parity clear
        run(7, 16'h00FF, 16'hAAAA, 1, "R2");
        run(8, 16'h8001, 16'h0001, 1, "R10");  // carry from top bit
        run(9, 16'h0002, 16'h0000, 1, "R10");  // zero amount keeps carry
        run(9, 16'h0002, 16'hFFF2, 1, "R3");   // only low bits count
        run(10, 16'h8000, 16'h000F, 1, "R3");
        run(1, 16'h0000, 16'h0001, 1, "R9");
        run(5, 16'h0000, 16'h0000, 1, "R9");
        run(0, 16'h7FFF, 16'h7FFF, 1, "R5");
        run(13, 16'h0000, 16'h0000, 1, "R13");
        run(0, 16'h0000, 16'h0000, 0, "R12");  // enable low holds

        for (int i = 0; i < 400; i++) begin
            int o = int'($urandom % 16);
            run(o, pick(), pick(), ($urandom % 4) != 0, tag_of(o));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule